// File: doc/BRIEF.md
# CAN Controller Soft-Reset and Bus Integration Controller

This block owns the soft-reset state of a CAN controller and decides when the node may take part in bus traffic again. A host changes the state through one bit of a main control register, bit 0 at address `CTL_ADDR`. Setting that bit puts the controller into soft reset at once. A one-cycle abort pulse tells the frame engine to drop whatever it is sending or receiving. The `regs_hold` output tells the flag, interrupt-enable and transmit-control registers to return to their reset values and stay there. The configuration register window opens for host writes.

When the host clears the bit, the block watches the sampled bus bits and counts consecutive recessive bits at each bit-time strobe. A node that is not bus-off is synchronized after one run of `RUN_LEN` recessive bits. A node that is bus-off must first collect `BOF_RUNS` such runs. When that recovery completes, a separate pulse lets logic outside the block clear the error counters. This block does not hold those counters, so they keep their values across soft reset.

Bit timing and frame coding are handled elsewhere. This block sees only a strobe, a sampled bit (1 = recessive, 0 = dominant) and the bus-off level.

Top module: `can_softrst_ctrl`

## Requirements
- R1: After reset, `soft_rst` and `regs_hold` are 1, `ctl_q` reads 0x01, and `synced`, `abort_pulse`, `sync_pulse`, `bof_done_pulse` and `cfg_we` are 0.
- R2: When soft reset is inactive, a host write to `CTL_ADDR` with data bit 0 = 1 has these effects one cycle later: `soft_rst` = 1, `synced` = 0, `ctl_q` = 0x01, and `abort_pulse` = 1 for exactly one cycle.
- R3: While soft reset is active, `ctl_q` bits 7..1 stay 0 whatever the host writes, and `regs_hold` stays 1.
- R4: `cfg_we` is 1 in the cycle of a host write to an address in `CFG_FIRST`..`CFG_LAST` (1..20 by default) only while soft reset is active. A write to any other address, or a write made outside soft reset, leaves `cfg_we` at 0.
- R5: A write to `CTL_ADDR` with bit 0 = 0 during soft reset clears soft reset and discards the other data bits, so `ctl_q` becomes 0x00.
- R6: Outside soft reset, with `bus_off` = 0, the edge that processes the `RUN_LEN`-th (11th) consecutive recessive strobe sets `synced` to 1 and raises `sync_pulse` for exactly one cycle.
- R7: A dominant strobe before a run is complete resets the run count, so a full `RUN_LEN` further recessive strobes are needed.
- R8: With `bus_off` = 1, synchronization happens only at the completion of the `BOF_RUNS`-th (128th) run. In that same cycle `bof_done_pulse` and `sync_pulse` are both 1 for one cycle. Earlier runs neither synchronize nor pulse.
- R9: Bus bits count only in cycles where `bit_stb` = 1 and soft reset is inactive.
- R10: Entering soft reset discards any partial run and any bus-off run progress.
- R11: Outside soft reset, a write to `CTL_ADDR` with bit 0 = 0 stores data bits 7..1 into `ctl_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| bit_stb | input | 1 | One-cycle strobe per bus bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| bus_off | input | 1 | Node is in the bus-off state |
| soft_rst | output | 1 | Soft reset active |
| ctl_q | output | DATA_W | Main control register contents |
| regs_hold | output | 1 | Hold status and control registers at reset values |
| cfg_we | output | 1 | Configuration register write enable |
| abort_pulse | output | 1 | One-cycle abort of the frame in progress |
| synced | output | 1 | Node is synchronized to the bus |
| sync_pulse | output | 1 | One-cycle pulse when synchronization is reached |
| bof_done_pulse | output | 1 | One-cycle pulse when bus-off recovery completes |

## Verification
The hardest case to reach is the last recovery run while bus-off. Reaching it from the ports takes 128 complete runs of 11 recessive strobes, and the stimulus has to show that none of the earlier runs synchronizes the node. The bench holds `bus_off` high, leaves soft reset, and drives 127 runs with a dominant bit placed partway into one of them. It then checks that `synced` is still low before it feeds the final run, and after that run it checks both pulses together.

// File: rtl/can_sr_pkg.sv
package can_sr_pkg;

   // Bit position of the soft-reset control inside the main control register
   localparam int SR_BIT_POS = 0;

   // Variant selector for the configuration write-enable path
   typedef enum logic {
      CFG_WE_COMB = 1'b0,
      CFG_WE_FLOP = 1'b1
   } cfg_we_mode_e;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/csr_ctl_reg.sv
module csr_ctl_reg #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8,
   parameter int CTL_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              soft_rst,
   output logic [DATA_W-1:0] ctl_q,
   output logic              abort_pulse
);
   import can_sr_pkg::*;

   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

   logic              sr_q;
   logic              abort_q;
   logic [DATA_W-1:1] bits_q;
   logic              ctl_hit;

   assign ctl_hit = wr && (addr == CTL_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= 1'b1;
         bits_q  <= '0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= 1'b0;
         if (ctl_hit) begin
            if (sr_q) begin
               // leaving soft reset: every other bit of the access is dropped
               if (!wdata[SR_BIT_POS])
                  sr_q <= 1'b0;
            end else if (wdata[SR_BIT_POS]) begin
               sr_q    <= 1'b1;
               bits_q  <= '0;
               abort_q <= 1'b1;
            end else begin
               bits_q <= wdata[DATA_W-1:1];
            end
         end
      end
   end

   assign soft_rst    = sr_q;
   assign abort_pulse = abort_q;
   assign ctl_q       = {bits_q, sr_q};

   AST_CTL_HELD_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
      sr_q |-> (bits_q == '0)); // R3
   AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> (sr_q && !$past(sr_q))); // R2
   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |=> !abort_q); // R2

endmodule

// File: rtl/csr_run_cnt.sv
module csr_run_cnt #(
   parameter int RUN_LEN = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   input  logic rec,
   output logic run_done
);
   import can_sr_pkg::*;

   localparam int            CW   = cnt_width(RUN_LEN);
   localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

   logic [CW-1:0] cnt_q;

   assign run_done = !clr && stb && rec && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (stb) begin
         if (!rec || (cnt_q == LAST))
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R7
   AST_DOMINANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !rec) |=> (cnt_q == '0)); // R7
   AST_RUN_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !clr) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/csr_bof_cnt.sv
module csr_bof_cnt #(
   parameter int BOF_RUNS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run_done,
   input  logic bus_off,
   output logic bof_done
);
   import can_sr_pkg::*;

   localparam int            CW   = cnt_width(BOF_RUNS);
   localparam logic [CW-1:0] LAST = CW'(BOF_RUNS - 1);

   logic [CW-1:0] cnt_q;
   logic          adv;

   assign adv      = !clr && run_done && bus_off;
   assign bof_done = adv && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || bof_done)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= cnt_q + 1'b1;
   end

   AST_BOF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R8
   AST_BOF_ONLY_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_done && !clr) |=> $stable(cnt_q)); // R8
   AST_BOF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/csr_cfg_decode.sv
module csr_cfg_decode #(
   parameter int ADDR_W    = 5,
   parameter int CFG_FIRST = 1,
   parameter int CFG_LAST  = 20
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              window_open,
   output logic              we
);
   localparam logic [ADDR_W-1:0] LO = ADDR_W'(CFG_FIRST);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(CFG_LAST);

   logic in_range;

   assign in_range = (addr >= LO) && (addr <= HI);
   assign we       = wr && in_range && window_open;

endmodule

// File: rtl/can_softrst_ctrl.sv
module can_softrst_ctrl #(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int CTL_ADDR   = 0,
   parameter int CFG_FIRST  = 1,
   parameter int CFG_LAST   = 20,
   parameter int RUN_LEN    = 11,
   parameter int BOF_RUNS   = 128,
   parameter bit CFG_WE_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              bit_stb,
   input  logic              bus_bit,
   input  logic              bus_off,
   output logic              soft_rst,
   output logic [DATA_W-1:0] ctl_q,
   output logic              regs_hold,
   output logic              cfg_we,
   output logic              abort_pulse,
   output logic              synced,
   output logic              sync_pulse,
   output logic              bof_done_pulse
);
   import can_sr_pkg::*;

   localparam cfg_we_mode_e WE_MODE = CFG_WE_REG ? CFG_WE_FLOP : CFG_WE_COMB;

   // elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (RUN_LEN < 2) begin : g_bad_run_len
      $error("RUN_LEN must be at least 2");
   end
   if (BOF_RUNS < 1) begin : g_bad_bof_runs
      $error("BOF_RUNS must be at least 1");
   end
   if (CFG_FIRST > CFG_LAST || CFG_LAST >= (1 << ADDR_W)) begin : g_bad_cfg_range
      $error("configuration window does not fit the address space");
   end
   if (CTL_ADDR >= CFG_FIRST && CTL_ADDR <= CFG_LAST) begin : g_bad_ctl_addr
      $error("CTL_ADDR overlaps the configuration window");
   end

   logic sr_w;
   logic run_done_w;
   logic bof_done_w;
   logic cnt_clr;
   logic sync_evt;
   logic synced_q;
   logic sync_pulse_q;
   logic bof_pulse_q;
   logic cfg_we_raw;

   csr_ctl_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTL_ADDR (CTL_ADDR)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (host_wr),
      .addr        (host_addr),
      .wdata       (host_wdata),
      .soft_rst    (sr_w),
      .ctl_q       (ctl_q),
      .abort_pulse (abort_pulse)
   );

   assign cnt_clr = sr_w || synced_q;

   csr_run_cnt #(
      .RUN_LEN (RUN_LEN)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .stb      (bit_stb),
      .rec      (bus_bit),
      .run_done (run_done_w)
   );

   csr_bof_cnt #(
      .BOF_RUNS (BOF_RUNS)
   ) u_bof (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .run_done (run_done_w),
      .bus_off  (bus_off),
      .bof_done (bof_done_w)
   );

   assign sync_evt = (run_done_w && !bus_off) || bof_done_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q     <= 1'b0;
         sync_pulse_q <= 1'b0;
         bof_pulse_q  <= 1'b0;
      end else begin
         sync_pulse_q <= sync_evt;
         bof_pulse_q  <= bof_done_w;
         if (sr_w)
            synced_q <= 1'b0;
         else if (sync_evt)
            synced_q <= 1'b1;
      end
   end

   csr_cfg_decode #(
      .ADDR_W    (ADDR_W),
      .CFG_FIRST (CFG_FIRST),
      .CFG_LAST  (CFG_LAST)
   ) u_cfg (
      .wr          (host_wr),
      .addr        (host_addr),
      .window_open (sr_w),
      .we          (cfg_we_raw)
   );

   if (WE_MODE == CFG_WE_FLOP) begin : g_we_flop
      logic we_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) we_q <= 1'b0;
         else        we_q <= cfg_we_raw;
      end
      assign cfg_we = we_q;
   end else begin : g_we_comb
      assign cfg_we = cfg_we_raw;
   end

   assign soft_rst       = sr_w;
   assign regs_hold      = sr_w;
   assign synced         = synced_q && !sr_w;
   assign sync_pulse     = sync_pulse_q;
   assign bof_done_pulse = bof_pulse_q;

   AST_CFG_ONLY_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> soft_rst); // R4
   AST_SYNC_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |=> !sync_pulse); // R6
   AST_SYNC_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> synced); // R6
   AST_BOF_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      bof_done_pulse |-> sync_pulse); // R8
   AST_SR_UNSYNCS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst) |-> !synced); // R2

endmodule

// File: tb/can_softrst_ctrl_tb.sv
module can_softrst_ctrl_tb;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic              bit_stb = 1'b0;
   logic              bus_bit = 1'b1;
   logic              bus_off = 1'b0;
   logic              soft_rst;
   logic [DATA_W-1:0] ctl_q;
   logic              regs_hold;
   logic              cfg_we;
   logic              abort_pulse;
   logic              synced;
   logic              sync_pulse;
   logic              bof_done_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   can_softrst_ctrl u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .host_wr        (host_wr),
      .host_addr      (host_addr),
      .host_wdata     (host_wdata),
      .bit_stb        (bit_stb),
      .bus_bit        (bus_bit),
      .bus_off        (bus_off),
      .soft_rst       (soft_rst),
      .ctl_q          (ctl_q),
      .regs_hold      (regs_hold),
      .cfg_we         (cfg_we),
      .abort_pulse    (abort_pulse),
      .synced         (synced),
      .sync_pulse     (sync_pulse),
      .bof_done_pulse (bof_done_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_addr = '0; host_wdata = '0;
   endtask

   task automatic strobe(input logic b);
      @(negedge clk);
      bit_stb = 1'b1; bus_bit = b;
      @(negedge clk);
      bit_stb = 1'b0; bus_bit = 1'b1;
   endtask

   task automatic recessive_n(input int n);
      for (int i = 0; i < n; i++) strobe(1'b1);
   endtask

   task automatic t_reset();
      chk("R1 soft_rst", soft_rst, 1);
      chk("R1 regs_hold", regs_hold, 1);
      chk("R1 ctl_q", ctl_q, 8'h01);
      chk("R1 synced", synced, 0);
      chk("R1 pulses", {abort_pulse, sync_pulse, bof_done_pulse, cfg_we}, 0);
   endtask

   task automatic t_cfg_window();
      @(negedge clk);
      host_wr = 1'b1; host_addr = 5'd5; host_wdata = 8'h33;
      #1 chk("R4 cfg_we inside window", cfg_we, 1);
      host_addr = 5'd20;
      #1 chk("R4 cfg_we last address", cfg_we, 1);
      host_addr = 5'd21;
      #1 chk("R4 cfg_we out of range", cfg_we, 0);
      @(negedge clk);
      host_wr = 1'b0; host_addr = '0;
      host_write(5'd0, 8'hFF);
      chk("R3 ctl held in soft reset", ctl_q, 8'h01);
      chk("R3 regs_hold", regs_hold, 1);
   endtask

   task automatic t_leave_sr();
      host_write(5'd0, 8'hAA);
      chk("R5 soft reset cleared", soft_rst, 0);
      chk("R5 other bits discarded", ctl_q, 8'h00);
      chk("R5 no abort on exit", abort_pulse, 0);
      @(negedge clk);
      host_wr = 1'b1; host_addr = 5'd5; host_wdata = 8'h11;
      #1 chk("R4 cfg_we closed outside soft reset", cfg_we, 0);
      @(negedge clk);
      host_wr = 1'b0; host_addr = '0;
   endtask

   task automatic t_sync_normal();
      recessive_n(10);
      chk("R6 not synced after 10", synced, 0);
      strobe(1'b1);
      chk("R6 synced after 11", synced, 1);
      chk("R6 sync_pulse", sync_pulse, 1);
      chk("R6 no bof pulse", bof_done_pulse, 0);
      @(negedge clk);
      chk("R6 sync_pulse one cycle", sync_pulse, 0);
   endtask

   task automatic t_ctl_active();
      host_write(5'd0, 8'h54);
      chk("R11 bits stored", ctl_q, 8'h54);
      host_write(5'd0, 8'h55);
      chk("R2 soft reset set", soft_rst, 1);
      chk("R2 abort pulse", abort_pulse, 1);
      chk("R2 synced dropped", synced, 0);
      chk("R2 ctl reset value", ctl_q, 8'h01);
      @(negedge clk);
      chk("R2 abort one cycle", abort_pulse, 0);
   endtask

   task automatic t_dominant_break();
      host_write(5'd0, 8'h00);
      recessive_n(7);
      strobe(1'b0);
      recessive_n(10);
      chk("R7 run restarted", synced, 0);
      strobe(1'b1);
      chk("R7 synced after full run", synced, 1);
   endtask

   task automatic t_stb_gate();
      host_write(5'd0, 8'h01);
      recessive_n(11);
      chk("R9 no sync during soft reset", synced, 0);
      host_write(5'd0, 8'h00);
      @(negedge clk);
      bus_bit = 1'b1;
      repeat (20) @(negedge clk);
      chk("R9 no count without strobe", synced, 0);
      recessive_n(10);
      chk("R9 nothing carried over", synced, 0);
      strobe(1'b1);
      chk("R9 synced after counted run", synced, 1);
   endtask

   task automatic t_reentry();
      host_write(5'd0, 8'h01);
      host_write(5'd0, 8'h00);
      recessive_n(6);
      host_write(5'd0, 8'h01);
      host_write(5'd0, 8'h00);
      recessive_n(10);
      chk("R10 partial run discarded", synced, 0);
      strobe(1'b1);
      chk("R10 synced after fresh run", synced, 1);
   endtask

   task automatic t_bus_off();
      bit early;
      early = 1'b0;
      host_write(5'd0, 8'h01);
      bus_off = 1'b1;
      recessive_n(5);
      host_write(5'd0, 8'h00);
      recessive_n(11 * 3 + 4);
      host_write(5'd0, 8'h01);
      host_write(5'd0, 8'h00);
      for (int r = 0; r < 127; r++) begin
         if (r == 40) begin
            recessive_n(6);
            strobe(1'b0);
         end
         for (int b = 0; b < 11; b++) begin
            strobe(1'b1);
            if (synced || sync_pulse || bof_done_pulse) early = 1'b1;
         end
      end
      chk("R8 no early sync while bus-off", early, 0);
      chk("R8 not synced after 127 runs", synced, 0);
      recessive_n(10);
      chk("R8 not synced mid last run", synced, 0);
      strobe(1'b1);
      chk("R8 synced after 128th run", synced, 1);
      chk("R8 bof_done_pulse", bof_done_pulse, 1);
      chk("R8 sync_pulse with recovery", sync_pulse, 1);
      @(negedge clk);
      chk("R8 bof pulse one cycle", bof_done_pulse, 0);
      bus_off = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_window();
      t_leave_sr();
      t_sync_normal();
      t_ctl_active();
      t_dominant_break();
      t_stb_gate();
      t_reentry();
      t_bus_off();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule